// File: doc/BRIEF.md
# Partitioned Message Slot Allocator

This block tracks which entries of a fixed pool of message buffers are occupied. It keeps one occupancy flag per slot. The payload storage sits elsewhere; the block only hands out and takes back slot numbers.

Two allocation ports are served each cycle, one for inbound (receive) traffic and one for outbound (transmit) traffic. A receive request may claim any slot. A transmit request may only claim slots from the upper three quarters of the pool. Keeping the lowest quarter for receive traffic means a reply can always be stored, even when outbound traffic has filled every slot it is allowed to use.

A single release port returns slots to the pool. It also accepts the release of one scratch buffer that lives outside the pool; such a release is acknowledged and leaves the pool untouched.

Top module: `slotAlloc`

## Requirements
- R1: After reset every slot is free, `freeCount` equals POOL_SIZE, and both `rxDone` and `txDone` are low.
- R2: A receive request in cycle N produces `rxDone`=1 in cycle N+1. `rxIdx` is the lowest-numbered free slot, counting from 0, and that slot becomes occupied.
- R3: A transmit request in cycle N produces `txDone`=1 in cycle N+1. `txIdx` is the lowest-numbered free slot at or above POOL_SIZE/4. A slot below POOL_SIZE/4 is never granted to transmit.
- R4: When no eligible slot is free, the response has the fail flag (`rxFail` or `txFail`) set to 1, and no flag changes.
- R5: When receive and transmit requests arrive in the same cycle, receive is served first. Transmit then searches the flags that already include the receive grant, so the two never get the same slot.
- R6: A release with `freeValid`=1 and `freeScratch`=0 clears the flag of slot `freeIdx`, and that slot can be granted again.
- R7: A release with `freeValid`=1 and `freeScratch`=1 targets the scratch buffer. `freeIdx` is ignored and no pool flag changes.
- R8: A release in the same cycle as an allocation takes effect before the search, so the slot it frees can be granted in that same cycle.
- R9: `freeCount` always equals the number of clear flags. It reflects the changes of cycle N from cycle N+1 onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxReq | input | 1 | Receive allocation request |
| txReq | input | 1 | Transmit allocation request |
| freeValid | input | 1 | Release request |
| freeScratch | input | 1 | Release targets the scratch buffer |
| freeIdx | input | IDX_W | Slot to release |
| rxDone | output | 1 | Receive response valid |
| rxFail | output | 1 | Receive found no free slot |
| rxIdx | output | IDX_W | Granted receive slot |
| txDone | output | 1 | Transmit response valid |
| txFail | output | 1 | Transmit found no eligible slot |
| txIdx | output | IDX_W | Granted transmit slot |
| freeCount | output | IDX_W+1 | Number of free slots |

## Verification
The hardest case to reach from the ports is a simultaneous receive and transmit request against an arbitrary occupancy pattern. It is hardest when only slots in the reserved quarter, or only one eligible slot, remain free.

The bench runs a pool of eight slots. For every one of the 256 occupancy patterns it builds the pattern through the ports: it fills the pool with receive grants, then releases the slots that should be clear. It then issues a dual request and compares the result with a model computed in the bench.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  typedef struct packed {
    logic doRx;
    logic doTx;
    logic doFree;
  } slotStrobes_t;
endpackage

// File: rtl/slotCtrl.sv
module slotCtrl
  import slot_alloc_pkg::*;
(
  input  logic         rxReq,
  input  logic         txReq,
  input  logic         freeValid,
  input  logic         freeScratch,
  output slotStrobes_t strobes
);
  // A scratch release is acknowledged but never reaches the pool flags.
  always_comb begin
    strobes.doRx   = rxReq;
    strobes.doTx   = txReq;
    strobes.doFree = freeValid && !freeScratch;
  end
endmodule

// File: rtl/slotFind.sv
module slotFind #(
  parameter int POOL_SIZE = 64,
  parameter int LO        = 0,
  localparam int IDX_W    = $clog2(POOL_SIZE)
) (
  input  logic [POOL_SIZE-1:0] used,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);
  // Lowest clear bit at or above LO; scanning downward lets the lowest win.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = POOL_SIZE - 1; i >= LO; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/slotDatapath.sv
module slotDatapath
  import slot_alloc_pkg::*;
#(
  parameter int POOL_SIZE = 64,
  localparam int IDX_W    = $clog2(POOL_SIZE),
  localparam int TX_BASE  = POOL_SIZE / 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  slotStrobes_t       strobes,
  input  logic [IDX_W-1:0]   freeIdx,
  output logic               rxDone,
  output logic               rxFail,
  output logic [IDX_W-1:0]   rxIdx,
  output logic               txDone,
  output logic               txFail,
  output logic [IDX_W-1:0]   txIdx,
  output logic [IDX_W:0]     freeCount
);
  localparam logic [POOL_SIZE-1:0] ONE = POOL_SIZE'(1);

  logic [POOL_SIZE-1:0] usedQ;
  logic [POOL_SIZE-1:0] afterFree;
  logic [POOL_SIZE-1:0] afterRx;
  logic [POOL_SIZE-1:0] usedD;
  logic                 rxFound;
  logic                 txFound;
  logic [IDX_W-1:0]     rxPick;
  logic [IDX_W-1:0]     txPick;

  // Release first, then receive, then transmit.
  always_comb begin
    afterFree = usedQ;
    if (strobes.doFree) afterFree = usedQ & ~(ONE << freeIdx);
  end

  slotFind #(.POOL_SIZE(POOL_SIZE), .LO(0)) u_rxFind (
    .used(afterFree), .found(rxFound), .idx(rxPick)
  );

  always_comb begin
    afterRx = afterFree;
    if (strobes.doRx && rxFound) afterRx = afterFree | (ONE << rxPick);
  end

  slotFind #(.POOL_SIZE(POOL_SIZE), .LO(TX_BASE)) u_txFind (
    .used(afterRx), .found(txFound), .idx(txPick)
  );

  always_comb begin
    usedD = afterRx;
    if (strobes.doTx && txFound) usedD = afterRx | (ONE << txPick);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedQ  <= '0;
      rxDone <= 1'b0;
      rxFail <= 1'b0;
      rxIdx  <= '0;
      txDone <= 1'b0;
      txFail <= 1'b0;
      txIdx  <= '0;
    end else begin
      usedQ  <= usedD;
      rxDone <= strobes.doRx;
      rxFail <= strobes.doRx && !rxFound;
      rxIdx  <= rxPick;
      txDone <= strobes.doTx;
      txFail <= strobes.doTx && !txFound;
      txIdx  <= txPick;
    end
  end

  always_comb begin
    freeCount = '0;
    for (int i = 0; i < POOL_SIZE; i++) begin
      freeCount = freeCount + (IDX_W+1)'(!usedQ[i]);
    end
  end
endmodule

// File: rtl/slotAlloc.sv
module slotAlloc
  import slot_alloc_pkg::*;
#(
  parameter int POOL_SIZE = 64,
  localparam int IDX_W    = $clog2(POOL_SIZE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxReq,
  input  logic             txReq,
  input  logic             freeValid,
  input  logic             freeScratch,
  input  logic [IDX_W-1:0] freeIdx,
  output logic             rxDone,
  output logic             rxFail,
  output logic [IDX_W-1:0] rxIdx,
  output logic             txDone,
  output logic             txFail,
  output logic [IDX_W-1:0] txIdx,
  output logic [IDX_W:0]   freeCount
);
  slotStrobes_t strobes;

  slotCtrl u_ctrl (
    .rxReq(rxReq), .txReq(txReq), .freeValid(freeValid),
    .freeScratch(freeScratch), .strobes(strobes)
  );

  slotDatapath #(.POOL_SIZE(POOL_SIZE)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .freeIdx(freeIdx),
    .rxDone(rxDone), .rxFail(rxFail), .rxIdx(rxIdx),
    .txDone(txDone), .txFail(txFail), .txIdx(txIdx),
    .freeCount(freeCount)
  );
endmodule

// File: rtl/slotAllocChk.sv
module slotAllocChk #(
  parameter int POOL_SIZE = 64,
  localparam int IDX_W    = $clog2(POOL_SIZE)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxReq,
  input logic             txReq,
  input logic             freeValid,
  input logic             freeScratch,
  input logic [IDX_W-1:0] freeIdx,
  input logic             rxDone,
  input logic             rxFail,
  input logic [IDX_W-1:0] rxIdx,
  input logic             txDone,
  input logic             txFail,
  input logic [IDX_W-1:0] txIdx,
  input logic [IDX_W:0]   freeCount
);
  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    freeCount <= (IDX_W+1)'(POOL_SIZE));

  assert_rx_response_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxReq && freeCount != 0 |=> rxDone && !rxFail);

  assert_tx_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    txDone && !txFail |-> int'(txIdx) >= POOL_SIZE / 4);

  assert_rx_empty_fail_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxReq && !freeValid && freeCount == 0 |=> rxDone && rxFail);

  assert_distinct_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && txDone && !rxFail && !txFail |-> rxIdx != txIdx);

  assert_scratch_noop_R7: assert property (@(posedge clk) disable iff (!rstN)
    freeValid && freeScratch && !rxReq && !txReq |=> $stable(freeCount));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxReq && !txReq && !freeValid |=> $stable(freeCount));
endmodule

bind slotAlloc slotAllocChk #(.POOL_SIZE(POOL_SIZE)) u_chk (.*);

// File: tb/slotAlloc_tb.sv
module slotAlloc_tb;
  localparam int P  = 8;
  localparam int IW = $clog2(P);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxReq = 1'b0, txReq = 1'b0, freeValid = 1'b0, freeScratch = 1'b0;
  logic [IW-1:0] freeIdx = '0;
  logic rxDone, rxFail, txDone, txFail;
  logic [IW-1:0] rxIdx, txIdx;
  logic [IW:0] freeCount;

  int checks = 0;
  int fails = 0;
  logic [P-1:0] model = '0;

  always #5 clk = ~clk;

  slotAlloc #(.POOL_SIZE(P)) u_dut (
    .clk(clk), .rstN(rstN), .rxReq(rxReq), .txReq(txReq),
    .freeValid(freeValid), .freeScratch(freeScratch), .freeIdx(freeIdx),
    .rxDone(rxDone), .rxFail(rxFail), .rxIdx(rxIdx),
    .txDone(txDone), .txFail(txFail), .txIdx(txIdx), .freeCount(freeCount)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int popFree(input logic [P-1:0] u);
    int n = 0;
    for (int i = 0; i < P; i++) if (!u[i]) n++;
    return n;
  endfunction

  // Called at a negedge; applies one cycle of stimulus and checks the response.
  task automatic op(input logic r, input logic t, input logic fv, input logic fs,
                    input int fi, input string tag);
    logic [P-1:0] u;
    int rxE, txE;
    u = model;
    if (fv && !fs) u[fi] = 1'b0;
    rxE = -1;
    if (r) begin
      for (int i = P - 1; i >= 0; i--) if (!u[i]) rxE = i;
      if (rxE >= 0) u[rxE] = 1'b1;
    end
    txE = -1;
    if (t) begin
      for (int i = P - 1; i >= P / 4; i--) if (!u[i]) txE = i;
      if (txE >= 0) u[txE] = 1'b1;
    end
    model = u;
    rxReq = r; txReq = t; freeValid = fv; freeScratch = fs; freeIdx = IW'(fi);
    @(negedge clk);
    rxReq = 0; txReq = 0; freeValid = 0; freeScratch = 0;
    chk(rxDone == r, tag, rxDone, r);
    chk(txDone == t, tag, txDone, t);
    if (r) begin
      chk(rxFail == (rxE < 0), tag, rxFail, rxE < 0);
      if (rxE >= 0) chk(int'(rxIdx) == rxE, tag, rxIdx, rxE);
    end
    if (t) begin
      chk(txFail == (txE < 0), tag, txFail, txE < 0);
      if (txE >= 0) chk(int'(txIdx) == txE, tag, txIdx, txE);
    end
    chk(int'(freeCount) == popFree(model), "R9", freeCount, popFree(model));
  endtask

  task automatic clearPool(input string tag);
    for (int i = 0; i < P; i++) op(0, 0, 1, 0, i, tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(int'(freeCount) == P, "R1", freeCount, P);
    chk(rxDone == 0 && txDone == 0, "R1", rxDone | txDone, 0);

    // R3 and R4: transmit fills the upper part, then fails; the reserved quarter stays free
    for (int i = 0; i < P - P / 4; i++) op(0, 1, 0, 0, 0, "R3");
    op(0, 1, 0, 0, 0, "R4");
    // R2: receive still takes the lowest slots
    for (int i = 0; i < P / 4; i++) op(1, 0, 0, 0, 0, "R2");
    op(1, 0, 0, 0, 0, "R4");
    // R7: scratch release leaves slot 0 occupied
    op(0, 0, 1, 1, 0, "R7");
    op(1, 0, 0, 0, 0, "R7");
    // R8: release and receive in the same cycle reuse the slot
    op(1, 0, 1, 0, 5, "R8");
    // R6: released slot is granted again
    op(0, 0, 1, 0, 3, "R6");
    op(0, 1, 0, 0, 0, "R6");

    // R5: every occupancy pattern with a dual request
    for (int p = 0; p < (1 << P); p++) begin
      clearPool("R6");
      for (int i = 0; i < P; i++) op(1, 0, 0, 0, 0, "R2");
      for (int i = 0; i < P; i++) if (!p[i]) op(0, 0, 1, 0, i, "R6");
      op(1, 1, 0, 0, 0, "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule